// File: doc/BRIEF.md
# Configuration BAR and Expansion-ROM Sizer

This block owns the base address registers and the expansion ROM register of one configuration-space function. It watches 32-bit configuration writes, keeps only those aimed at the six base address slots or the ROM slot, and works out what each register must hold afterwards. Firmware finds out how large a window is by writing all ones and reading back a mask. Memory windows stay at their fixed reset address. I/O windows can be moved, and the block stores their new base.

Each time an I/O register takes a write, the block raises a one-cycle move event. The event carries the slot index, the old and new 16-bit port bases and the window size. An I/O port decoder downstream uses it to shift its window. The configuration offset arrives as a dword index, so the two byte-address bits are already dropped.

A small controller sequences the work. In `ST_IDLE` nothing is pending. Transition *bar_hit* enters `ST_BAR_COMMIT`: a write to a base address slot has been captured and is committed on the next edge. Transition *rom_hit* enters `ST_ROM_COMMIT` in the same way for the ROM slot. Transition *miss* returns to `ST_IDLE`. All three transitions can be taken from every state, so back-to-back writes never stall.

Top module: `ccfg_bar_sizer`

## Requirements
- R1: After reset, every implemented slot holds its reset value, with bit 0 forced to 1 for I/O slots and to 0 for memory slots. Unimplemented slots and a missing ROM read zero, an existing ROM reads its fixed address, and `move_valid` is 0.
- R2: Dword index 4+i addresses base address slot i (i = 0..5), and dword index 12 addresses the ROM slot. A write to any other index changes no output.
- R3: A write is a size probe when (data | 3 | (size-1)) is all ones. The slot then holds ~(size-1), with bit 0 set to the slot's type (1 = I/O, 0 = memory). Bit 0 of the current value gives the type.
- R4: A write to a memory slot that is not a probe puts the slot back to its reset value.
- R5: A write to an I/O slot that is not a probe stores data | 1.
- R6: Every write to an I/O slot, probe included, raises `move_valid` for exactly one cycle. The event carries `move_index` = slot, `move_from` = old value[15:0] with bit 0 cleared, `move_to` = new value[15:0] with bit 0 cleared, and `move_size` = slot size.
- R7: A write to an unimplemented slot (size 0) leaves it at zero and raises no move event.
- R8: A ROM write where (data | 0x7FF) is all ones makes the ROM register hold the two's-complement negation of the ROM size.
- R9: Any other ROM write makes it hold the fixed ROM address. When the ROM size is 0, the register always reads zero.
- R10: A write sampled at edge k appears on the outputs after edge k+1. Writes on consecutive cycles are applied in order, each with its own move event.
- R11: While no write is pending, all slot and ROM values stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | 32-bit configuration write strobe |
| wr_dword | input | 6 | Configuration dword index of the write |
| wr_data | input | 32 | Write data |
| bar_values | output | 32*NUM_BARS | Effective slot values; slot i in bits [32i+31:32i] |
| rom_value | output | 32 | Effective expansion ROM register |
| move_valid | output | 1 | One-cycle I/O window move event |
| move_index | output | $clog2(NUM_BARS) | Slot that moved |
| move_from | output | 16 | Old port base |
| move_to | output | 16 | New port base |
| move_size | output | 32 | Window length in ports |

## Verification
The bench sends probes whose low two data bits are set or cleared, and near-probes that are one bit away from a mask. A design that tested for an exact all-ones word, or that left out the size mask, would then report the wrong mask or fail to restore a memory slot. I/O probes must still raise a move event whose target is the probe mask, so a design that skipped the event on probes would be caught. The bench also checks that a pulse lasts exactly one cycle and that consecutive writes produce two events in order. Unimplemented slots, a function with no ROM, and dword indexes just outside the decoded range must all leave their values unchanged.

// File: rtl/ccfg_bar_pkg.sv
package ccfg_bar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BAR_COMMIT,
        ST_ROM_COMMIT
    } cfg_state_e;

    localparam int unsigned DW_BAR_FIRST = 4;
    localparam int unsigned DW_ROM       = 12;
    localparam int unsigned ROM_LOW_MASK = 32'h0000_07FF;

    function automatic logic is_size_probe(input logic [31:0] data,
                                           input logic [31:0] size_m1);
        return (data | 32'h0000_0003 | size_m1) == 32'hFFFF_FFFF;
    endfunction

endpackage

// File: rtl/ccfg_offset_decode.sv
module ccfg_offset_decode
    import ccfg_bar_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    localparam int unsigned IDX_W   = $clog2(NUM_BARS)
) (
    input  logic [5:0]       dword,
    output logic             hit_bar,
    output logic             hit_rom,
    output logic [IDX_W-1:0] bar_idx
);
    logic [5:0] rel;

    always_comb begin
        rel     = dword - 6'(DW_BAR_FIRST);
        hit_bar = (dword >= 6'(DW_BAR_FIRST)) &&
                  (dword <  6'(DW_BAR_FIRST + NUM_BARS));
        hit_rom = (dword == 6'(DW_ROM));
        bar_idx = IDX_W'(rel);
    end
endmodule

// File: rtl/ccfg_bar_slot.sv
module ccfg_bar_slot
    import ccfg_bar_pkg::*;
#(
    parameter logic [31:0] SIZE      = 32'h0,
    parameter logic [31:0] RESET_VAL = 32'h0
) (
    input  logic        cur_type,
    input  logic [31:0] data,
    output logic [31:0] nxt,
    output logic        moves
);
    localparam logic        IMPL    = (SIZE != 32'h0);
    localparam logic [31:0] SIZE_M1 = SIZE - 32'h1;

    logic probe;

    always_comb begin
        probe = is_size_probe(data, SIZE_M1);
        nxt   = 32'h0;
        moves = 1'b0;
        if (IMPL) begin
            if (cur_type) begin
                nxt   = probe ? (~SIZE_M1 | 32'h1) : (data | 32'h1);
                moves = 1'b1;
            end else begin
                nxt   = probe ? (~SIZE_M1 & ~32'h1) : RESET_VAL;
            end
        end
    end
endmodule

// File: rtl/ccfg_rom_slot.sv
module ccfg_rom_slot
    import ccfg_bar_pkg::*;
#(
    parameter logic [31:0] ROM_SIZE = 32'h0,
    parameter logic [31:0] ROM_ADDR = 32'h0
) (
    input  logic [31:0] data,
    output logic [31:0] nxt
);
    localparam logic PRESENT = (ROM_SIZE != 32'h0);

    always_comb begin
        if (!PRESENT)
            nxt = 32'h0;
        else if ((data | 32'(ROM_LOW_MASK)) == 32'hFFFF_FFFF)
            nxt = 32'h0 - ROM_SIZE;
        else
            nxt = ROM_ADDR;
    end
endmodule

// File: rtl/ccfg_bar_sizer.sv
module ccfg_bar_sizer
    import ccfg_bar_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    parameter logic [NUM_BARS*32-1:0] BAR_SIZES = {
        32'h0, 32'h0010_0000, 32'h0, 32'h0000_0008, 32'h0000_0020, 32'h0000_1000},
    parameter logic [NUM_BARS*32-1:0] BAR_RESETS = {
        32'h0, 32'hFE00_0000, 32'h0, 32'h0000_D001, 32'h0000_C001, 32'hFEB0_0000},
    parameter logic [NUM_BARS-1:0] BAR_IO_MASK = 6'b000110,
    parameter logic [31:0] ROM_SIZE = 32'h0001_0000,
    parameter logic [31:0] ROM_ADDR = 32'hFEC0_0000,
    localparam int unsigned IDX_W   = $clog2(NUM_BARS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [5:0]             wr_dword,
    input  logic [31:0]            wr_data,
    output logic [NUM_BARS*32-1:0] bar_values,
    output logic [31:0]            rom_value,
    output logic                   move_valid,
    output logic [IDX_W-1:0]       move_index,
    output logic [15:0]            move_from,
    output logic [15:0]            move_to,
    output logic [31:0]            move_size
);
    localparam logic [31:0] ROM_RESET = (ROM_SIZE != 32'h0) ? ROM_ADDR : 32'h0;

    cfg_state_e       state_q, state_d;
    logic [IDX_W-1:0] pend_idx_q;
    logic [31:0]      pend_data_q;

    logic             hit_bar, hit_rom;
    logic [IDX_W-1:0] dec_idx;

    logic [31:0] bar_q      [NUM_BARS];
    logic [31:0] slot_nxt   [NUM_BARS];
    logic [31:0] slot_reset [NUM_BARS];
    logic [31:0] slot_size  [NUM_BARS];
    logic        slot_moves [NUM_BARS];
    logic [31:0] rom_q, rom_nxt;

    ccfg_offset_decode #(.NUM_BARS(NUM_BARS)) u_decode (
        .dword   (wr_dword),
        .hit_bar (hit_bar),
        .hit_rom (hit_rom),
        .bar_idx (dec_idx)
    );

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
        localparam logic [31:0] SZ = BAR_SIZES[i*32 +: 32];
        localparam logic [31:0] RV = BAR_RESETS[i*32 +: 32];
        localparam logic [31:0] RV_TYPED =
            (SZ == 32'h0)   ? 32'h0 :
            BAR_IO_MASK[i]  ? (RV | 32'h1) : (RV & ~32'h1);

        ccfg_bar_slot #(.SIZE(SZ), .RESET_VAL(RV_TYPED)) u_slot (
            .cur_type (bar_q[i][0]),
            .data     (pend_data_q),
            .nxt      (slot_nxt[i]),
            .moves    (slot_moves[i])
        );

        assign slot_reset[i]          = RV_TYPED;
        assign slot_size[i]           = SZ;
        assign bar_values[i*32 +: 32] = bar_q[i];
    end

    ccfg_rom_slot #(.ROM_SIZE(ROM_SIZE), .ROM_ADDR(ROM_ADDR)) u_rom (
        .data (pend_data_q),
        .nxt  (rom_nxt)
    );

    assign rom_value = rom_q;

    // Next-state logic: the transitions are named bar_hit, rom_hit and miss.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_BAR_COMMIT, ST_ROM_COMMIT: begin
                if (wr_en && hit_bar)      state_d = ST_BAR_COMMIT;  // bar_hit
                else if (wr_en && hit_rom) state_d = ST_ROM_COMMIT;  // rom_hit
                else                       state_d = ST_IDLE;        // miss
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and capture of the pending write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                pend_idx_q  <= dec_idx;
                pend_data_q <= wr_data;
            end
        end
    end

    // Outputs: commit the pending write and raise the move event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BARS; i++) bar_q[i] <= slot_reset[i];
            rom_q      <= ROM_RESET;
            move_valid <= 1'b0;
            move_index <= '0;
            move_from  <= '0;
            move_to    <= '0;
            move_size  <= '0;
        end else begin
            move_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_BAR_COMMIT: begin
                    bar_q[pend_idx_q] <= slot_nxt[pend_idx_q];
                    if (slot_moves[pend_idx_q]) begin
                        move_valid <= 1'b1;
                        move_index <= pend_idx_q;
                        move_from  <= {bar_q[pend_idx_q][15:1], 1'b0};
                        move_to    <= {slot_nxt[pend_idx_q][15:1], 1'b0};
                        move_size  <= slot_size[pend_idx_q];
                    end
                end
                ST_ROM_COMMIT: rom_q <= rom_nxt;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ccfg_bar_sizer_chk.sv
module ccfg_bar_sizer_chk
    import ccfg_bar_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    parameter logic [NUM_BARS*32-1:0] BAR_SIZES  = '0,
    parameter logic [NUM_BARS*32-1:0] BAR_RESETS = '0,
    parameter logic [NUM_BARS-1:0]    BAR_IO_MASK = '0,
    parameter logic [31:0] ROM_SIZE = 32'h0,
    parameter logic [31:0] ROM_ADDR = 32'h0,
    localparam int unsigned IDX_W   = $clog2(NUM_BARS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input cfg_state_e             state_q,
    input logic [NUM_BARS*32-1:0] bar_values,
    input logic [31:0]            rom_value,
    input logic                   move_valid,
    input logic [IDX_W-1:0]       move_index,
    input logic [15:0]            move_to
);
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_chk
        localparam logic [31:0] SZ = BAR_SIZES[i*32 +: 32];
        localparam logic [31:0] RV = BAR_RESETS[i*32 +: 32];
        if (SZ == 32'h0) begin : g_none
            assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                bar_values[i*32 +: 32] == 32'h0);
        end else if (BAR_IO_MASK[i]) begin : g_io
            assert_io_type_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
                bar_values[i*32] == 1'b1);
        end else begin : g_mem
            assert_mem_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (bar_values[i*32 +: 32] == (RV & ~32'h1)) ||
                (bar_values[i*32 +: 32] == ~(SZ - 32'h1)));
        end
    end

    assert_move_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        move_valid |-> move_to == {bar_values[move_index*32 + 1 +: 15], 1'b0});

    assert_move_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        move_valid |-> $past(state_q) == ST_BAR_COMMIT);

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(bar_values) && $stable(rom_value)));

    assert_rom_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ROM_SIZE == 32'h0) ? (rom_value == 32'h0) :
        ((rom_value == ROM_ADDR) || (rom_value == 32'h0 - ROM_SIZE)));
endmodule

bind ccfg_bar_sizer ccfg_bar_sizer_chk #(
    .NUM_BARS    (NUM_BARS),
    .BAR_SIZES   (BAR_SIZES),
    .BAR_RESETS  (BAR_RESETS),
    .BAR_IO_MASK (BAR_IO_MASK),
    .ROM_SIZE    (ROM_SIZE),
    .ROM_ADDR    (ROM_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .bar_values (bar_values),
    .rom_value  (rom_value),
    .move_valid (move_valid),
    .move_index (move_index),
    .move_to    (move_to)
);

// File: tb/test_ccfg_bar_sizer.sv
module test_ccfg_bar_sizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_dword = '0;
    logic [31:0] wr_data = '0;

    logic [191:0] bar_values, nr_bars;
    logic [31:0]  rom_value, nr_rom, move_size, nr_size;
    logic         move_valid, nr_valid;
    logic [2:0]   move_index, nr_index;
    logic [15:0]  move_from, move_to, nr_from, nr_to;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ccfg_bar_sizer i_ccfg_bar_sizer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dword(wr_dword), .wr_data(wr_data),
        .bar_values(bar_values), .rom_value(rom_value), .move_valid(move_valid),
        .move_index(move_index), .move_from(move_from), .move_to(move_to),
        .move_size(move_size)
    );

    ccfg_bar_sizer #(.ROM_SIZE(32'h0)) i_ccfg_bar_sizer_norom (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dword(wr_dword), .wr_data(wr_data),
        .bar_values(nr_bars), .rom_value(nr_rom), .move_valid(nr_valid),
        .move_index(nr_index), .move_from(nr_from), .move_to(nr_to),
        .move_size(nr_size)
    );

    typedef struct packed {
        logic [5:0]  dw;
        logic [31:0] data;
        logic [2:0]  slot;   // 0..5 base address slot, 6 = ROM
        logic [31:0] exp;
        logic        mv;
        logic [15:0] from;
        logic [15:0] to;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{6'd4,  32'hFFFF_FFFF, 3'd0, 32'hFFFF_F000, 1'b0, 16'h0,    16'h0},    // R3
        '{6'd4,  32'h1234_5670, 3'd0, 32'hFEB0_0000, 1'b0, 16'h0,    16'h0},    // R4
        '{6'd4,  32'hFFFF_F000, 3'd0, 32'hFFFF_F000, 1'b0, 16'h0,    16'h0},    // R3
        '{6'd4,  32'hFFFF_E000, 3'd0, 32'hFEB0_0000, 1'b0, 16'h0,    16'h0},    // R4
        '{6'd5,  32'h0000_E000, 3'd1, 32'h0000_E001, 1'b1, 16'hC000, 16'hE000}, // R5 R6
        '{6'd5,  32'hFFFF_FFFF, 3'd1, 32'hFFFF_FFE1, 1'b1, 16'hE000, 16'hFFE0}, // R3 R6
        '{6'd5,  32'h0000_B000, 3'd1, 32'h0000_B001, 1'b1, 16'hFFE0, 16'hB000}, // R5 R6
        '{6'd6,  32'h0001_2345, 3'd2, 32'h0001_2345, 1'b1, 16'hD000, 16'h2344}, // R5 R6
        '{6'd7,  32'hFFFF_FFFF, 3'd3, 32'h0000_0000, 1'b0, 16'h0,    16'h0},    // R7
        '{6'd9,  32'hABCD_0001, 3'd5, 32'h0000_0000, 1'b0, 16'h0,    16'h0},    // R7
        '{6'd8,  32'hFFFF_FFFF, 3'd4, 32'hFFF0_0000, 1'b0, 16'h0,    16'h0},    // R3
        '{6'd8,  32'h0000_0000, 3'd4, 32'hFE00_0000, 1'b0, 16'h0,    16'h0},    // R4
        '{6'd12, 32'hFFFF_F800, 3'd6, 32'hFFFF_0000, 1'b0, 16'h0,    16'h0},    // R8
        '{6'd12, 32'h1234_5678, 3'd6, 32'hFEC0_0000, 1'b0, 16'h0,    16'h0},    // R9
        '{6'd12, 32'hFFFF_FFFF, 3'd6, 32'hFFFF_0000, 1'b0, 16'h0,    16'h0}     // R8
    };

    function automatic logic [31:0] slot_size(input logic [2:0] s);
        case (s)
            3'd1:    return 32'h20;
            3'd2:    return 32'h8;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge after the commit edge.
    task automatic cfg_write(input logic [5:0] dw, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_dword = dw; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] slot_val(input logic [2:0] s);
        return (s == 3'd6) ? rom_value : bar_values[s*32 +: 32];
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [191:0] snap_bars;
        logic [31:0]  snap_rom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 bar0", bar_values[31:0],    32'hFEB0_0000);
        check("R1 bar1", bar_values[63:32],   32'h0000_C001);
        check("R1 bar2", bar_values[95:64],   32'h0000_D001);
        check("R1 bar3", bar_values[127:96],  32'h0);
        check("R1 bar4", bar_values[159:128], 32'hFE00_0000);
        check("R1 bar5", bar_values[191:160], 32'h0);
        check("R1 rom",  rom_value,           32'hFEC0_0000);
        check("R1 move", {31'h0, move_valid}, 32'h0);
        check("R1 norom", nr_rom,             32'h0);

        // Vector table: R2..R9
        for (int v = 0; v < NV; v++) begin
            cfg_write(VECS[v].dw, VECS[v].data);
            check($sformatf("R2 R3 R4 R5 R7 R8 R9 vec%0d value", v), slot_val(VECS[v].slot), VECS[v].exp);
            check($sformatf("R6 vec%0d move_valid", v), {31'h0, move_valid}, {31'h0, VECS[v].mv});
            if (VECS[v].mv) begin
                check($sformatf("R6 vec%0d index", v), {29'h0, move_index}, {29'h0, VECS[v].slot});
                check($sformatf("R6 vec%0d from", v),  {16'h0, move_from}, {16'h0, VECS[v].from});
                check($sformatf("R6 vec%0d to", v),    {16'h0, move_to},   {16'h0, VECS[v].to});
                check($sformatf("R6 vec%0d size", v),  move_size, slot_size(VECS[v].slot));
            end
            @(negedge clk);
            check($sformatf("R6 vec%0d pulse ends", v), {31'h0, move_valid}, 32'h0);
        end

        // R9: function without ROM always reads zero
        check("R9 norom after writes", nr_rom, 32'h0);

        // R2 R11: unmapped dword indexes change nothing
        snap_bars = bar_values;
        snap_rom  = rom_value;
        cfg_write(6'd10, 32'hFFFF_FFFF);
        cfg_write(6'd3,  32'h0000_0000);
        cfg_write(6'd13, 32'hFFFF_FFFF);
        check("R2 unmapped bars", {31'h0, bar_values == snap_bars}, 32'h1);
        check("R2 unmapped rom",  rom_value, snap_rom);
        check("R11 no move",      {31'h0, move_valid}, 32'h0);
        repeat (5) @(negedge clk);
        check("R11 idle bars stable", {31'h0, bar_values == snap_bars}, 32'h1);

        // R10: back-to-back writes applied in order
        @(negedge clk);
        wr_en = 1'b1; wr_dword = 6'd5; wr_data = 32'h0000_1000;
        @(negedge clk);
        wr_dword = 6'd6; wr_data = 32'h0000_2000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 first move valid", {31'h0, move_valid}, 32'h1);
        check("R10 first index", {29'h0, move_index}, 32'd1);
        check("R10 first from",  {16'h0, move_from}, 32'h0000_B000);
        check("R10 first to",    {16'h0, move_to},   32'h0000_1000);
        check("R10 bar1", bar_values[63:32], 32'h0000_1001);
        @(negedge clk);
        check("R10 second move valid", {31'h0, move_valid}, 32'h1);
        check("R10 second index", {29'h0, move_index}, 32'd2);
        check("R10 second from",  {16'h0, move_from}, 32'h0000_2344);
        check("R10 second to",    {16'h0, move_to},   32'h0000_2000);
        check("R10 second size",  move_size, 32'h8);
        check("R10 bar2", bar_values[95:64], 32'h0000_2001);
        @(negedge clk);
        check("R10 pulses end", {31'h0, move_valid}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule